// File: doc/BRIEF.md
# Victim Cache for a Direct-Mapped Cache

This block is a small fully associative store of blocks that a direct-mapped main cache has thrown out on misses. It sits on the refill path. Each main-cache miss presents a lookup carrying the missed block address and, when the main-cache line being replaced is valid, that outgoing block with its dirty state. All entries are searched before anything is requested from the next memory level.

On a hit, the found block and its dirty state are returned to the main cache. The outgoing main-cache block takes over the entry the found block occupied, so the two blocks swap places. On a miss, a memory request is raised for the missed address. The outgoing block is then written into an invalid entry if one exists, or else over the least recently used entry. If that entry held a dirty block, the block is sent out on the writeback port.

Top module: `victim_cache`

## Requirements
- R1: Reset clears every entry to invalid and drives `rsp_valid`, `mem_req_valid` and `wb_valid` low.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and low otherwise.
- R3: A lookup hits when any valid entry's stored block address equals `lk_addr`. On a hit, `rsp_hit` is 1 and `rsp_data` and `rsp_dirty` carry that entry's block data and dirty bit.
- R4: `mem_req_valid` is high, with `mem_req_addr` equal to the looked-up address, in the response cycle of every miss and of no hit.
- R5: On a hit with `ev_valid` high, the outgoing block (address, data, dirty bit) replaces the hit entry. A later lookup of the outgoing address hits, and a later lookup of the old address misses.
- R6: On a hit with `ev_valid` low, the hit entry becomes invalid, and a later lookup of that address misses.
- R7: On a miss with `ev_valid` high, the outgoing block is inserted. An invalid entry is taken first, the lowest-numbered one, before any valid entry is replaced.
- R8: When no entry is invalid, a miss insert replaces the least recently used entry. An entry counts as used when it is filled by an insert or by a swap.
- R9: When a miss insert replaces a valid dirty entry, `wb_valid` is high in the response cycle with that entry's address and data on `wb_addr`/`wb_data`. Replacing a clean entry raises no writeback.
- R10: A miss with `ev_valid` low inserts nothing and raises no writeback.
- R11: The default capacity is four entries, set by the parameter `ENTRIES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request for a main-cache miss |
| lk_addr | input | ADDR_W | Missed block address |
| ev_valid | input | 1 | An outgoing main-cache block accompanies the lookup |
| ev_addr | input | ADDR_W | Outgoing block address |
| ev_data | input | DATA_W | Outgoing block data |
| ev_dirty | input | 1 | Outgoing block is dirty |
| rsp_valid | output | 1 | Lookup result is valid |
| rsp_hit | output | 1 | Lookup found the block |
| rsp_data | output | DATA_W | Data of the found block |
| rsp_dirty | output | 1 | Dirty state of the found block |
| mem_req_valid | output | 1 | Request to lower memory |
| mem_req_addr | output | ADDR_W | Address requested from lower memory |
| wb_valid | output | 1 | Dirty block pushed out of the store |
| wb_addr | output | ADDR_W | Address of the pushed-out block |
| wb_data | output | DATA_W | Data of the pushed-out block |

## Verification
The assertion on hit uniqueness assumes that the main cache and this store hold disjoint blocks. Under that assumption, a lookup address is never already in the store alongside an outgoing block with the same address, and no outgoing address duplicates a stored one. The stimulus keeps to this by modelling a consistent exclusive hierarchy. Each outgoing address is one that the scenario has placed in the main cache and not in the store, and lookups target only addresses that are absent from the main cache.

// File: rtl/victim_cache.sv
module victim_cache #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              ev_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, drt, hit_vec;
  logic [ADDR_W-1:0]  tag [ENTRIES];
  logic [DATA_W-1:0]  dat [ENTRIES];
  logic [IW-1:0]      age [ENTRIES];
  logic [IW-1:0]      hit_idx, free_idx, lru_idx, slot;
  logic               any_hit, any_free;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    lru_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      hit_vec[i] = vld[i] && (tag[i] == lk_addr);
      if (hit_vec[i]) hit_idx = IW'(i);
      if (!vld[i]) free_idx = IW'(i);
      if (age[i] == IW'(ENTRIES - 1)) lru_idx = IW'(i);
    end
  end

  assign any_hit  = |hit_vec;
  assign any_free = ~&vld;
  assign slot     = any_hit ? hit_idx : (any_free ? free_idx : lru_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld           <= '0;
      drt           <= '0;
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_data      <= '0;
      rsp_dirty     <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      wb_valid      <= 1'b0;
      wb_addr       <= '0;
      wb_data       <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        age[i] <= IW'(i);
        tag[i] <= '0;
        dat[i] <= '0;
      end
    end else begin
      rsp_valid     <= lk_valid;
      mem_req_valid <= lk_valid && !any_hit;
      wb_valid      <= lk_valid && !any_hit && ev_valid && vld[slot] && drt[slot];
      if (lk_valid) begin
        rsp_hit      <= any_hit;
        rsp_data     <= any_hit ? dat[hit_idx] : '0;
        rsp_dirty    <= any_hit && drt[hit_idx];
        mem_req_addr <= lk_addr;
        wb_addr      <= tag[slot];
        wb_data      <= dat[slot];
      end
      if (lk_valid && ev_valid) begin
        vld[slot] <= 1'b1;
        drt[slot] <= ev_dirty;
        tag[slot] <= ev_addr;
        dat[slot] <= ev_data;
        for (int i = 0; i < ENTRIES; i++) begin
          if (IW'(i) == slot)        age[i] <= '0;
          else if (age[i] < age[slot]) age[i] <= age[i] + 1'b1;
        end
      end else if (lk_valid && any_hit) begin
        vld[hit_idx] <= 1'b0;
      end
    end
  end

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r3_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r4_req_only_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> rsp_valid && !rsp_hit);
  a_r4_miss_requests: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> mem_req_valid);
  a_r4_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> mem_req_addr == $past(lk_addr));
  a_r6_hit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && any_hit && !ev_valid |=> $countones(vld) == $past($countones(vld)) - 1);
  a_r9_wb_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> mem_req_valid);
  a_r10_no_wb_without_block: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !ev_valid |=> !wb_valid);
endmodule

// File: tb/victim_cache_test.sv
`timescale 1ns/1ps
module victim_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, ev_valid = 1'b0, ev_dirty = 1'b0;
  logic [15:0] lk_addr = '0, ev_addr = '0;
  logic [31:0] ev_data = '0;
  logic        rsp_valid, rsp_hit, rsp_dirty, mem_req_valid, wb_valid;
  logic [31:0] rsp_data, wb_data;
  logic [15:0] mem_req_addr, wb_addr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  victim_cache uut (.clk, .rst_n, .lk_valid, .lk_addr, .ev_valid, .ev_addr, .ev_data,
    .ev_dirty, .rsp_valid, .rsp_hit, .rsp_data, .rsp_dirty, .mem_req_valid,
    .mem_req_addr, .wb_valid, .wb_addr, .wb_data);

  function automatic logic [31:0] pat(logic [15:0] a);
    return {~a, a};
  endfunction

  typedef struct packed {
    logic [15:0] la; logic ev; logic [15:0] ea; logic ed;
    logic hit; logic hd; logic wb; logic [15:0] wa;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{16'h100, 1'b1, 16'h200, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R7 fill slot0
    '{16'h101, 1'b1, 16'h201, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},   // R7
    '{16'h102, 1'b1, 16'h202, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R7
    '{16'h103, 1'b1, 16'h203, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},   // R7 R11 full at four
    '{16'h201, 1'b1, 16'h100, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0},   // R5 swap
    '{16'h104, 1'b1, 16'h204, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},   // R8 replace 200 clean
    '{16'h105, 1'b1, 16'h205, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R8 replace 202
    '{16'h106, 1'b1, 16'h206, 1'b0, 1'b0, 1'b0, 1'b1, 16'h203}, // R8 R9 dirty out
    '{16'h200, 1'b0, 16'h0,   1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R10
    '{16'h204, 1'b0, 16'h0,   1'b0, 1'b1, 1'b1, 1'b0, 16'h0},   // R6 hit, no block in
    '{16'h204, 1'b0, 16'h0,   1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R6 now gone
    '{16'h107, 1'b1, 16'h207, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},   // R7 invalid first
    '{16'h108, 1'b1, 16'h208, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R8 replace 100
    '{16'h100, 1'b0, 16'h0,   1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R5 old swap block gone
    '{16'h207, 1'b1, 16'h109, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0},   // R5 swap, dirty in
    '{16'h10A, 1'b1, 16'h20A, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R8
    '{16'h10B, 1'b1, 16'h20B, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R8
    '{16'h10C, 1'b1, 16'h20C, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R8
    '{16'h10D, 1'b1, 16'h20D, 1'b0, 1'b0, 1'b0, 1'b1, 16'h109}, // R9 swapped dirty leaves
    '{16'h109, 1'b0, 16'h0,   1'b0, 1'b0, 1'b0, 1'b0, 16'h0},   // R8
    '{16'h20A, 1'b0, 16'h0,   1'b0, 1'b1, 1'b0, 1'b0, 16'h0}    // R3 clean hit
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input vec_t v);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = v.la; ev_valid = v.ev; ev_addr = v.ea;
    ev_data = pat(v.ea); ev_dirty = v.ed;
    @(negedge clk);
    lk_valid = 1'b0; ev_valid = 1'b0;
    check(rsp_valid, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
    check(rsp_hit == v.hit, "R3 hit", 64'(rsp_hit), 64'(v.hit));
    if (v.hit) begin
      check(rsp_data == pat(v.la), "R3 data", 64'(rsp_data), 64'(pat(v.la)));
      check(rsp_dirty == v.hd, "R3 dirty", 64'(rsp_dirty), 64'(v.hd));
    end
    check(mem_req_valid == !v.hit, "R4 request", 64'(mem_req_valid), 64'(!v.hit));
    if (!v.hit)
      check(mem_req_addr == v.la, "R4 address", 64'(mem_req_addr), 64'(v.la));
    check(wb_valid == v.wb, "R9 wb_valid", 64'(wb_valid), 64'(v.wb));
    if (v.wb) begin
      check(wb_addr == v.wa, "R9 wb_addr", 64'(wb_addr), 64'(v.wa));
      check(wb_data == pat(v.wa), "R9 wb_data", 64'(wb_data), 64'(pat(v.wa)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!rsp_valid && !mem_req_valid && !wb_valid, "R1 outputs in reset",
          64'({rsp_valid, mem_req_valid, wb_valid}), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) lookup(VEC[i]);
    @(negedge clk);
    check(!rsp_valid, "R2 idle", 64'(rsp_valid), 64'd0);
    lookup('{16'h20B, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0});
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R1: entries cleared, previously present 20C now misses
    lookup('{16'h20C, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule